// File: doc/BRIEF.md
# Edge-Selectable Capture/Compare Timer

A 16-bit up-counter paired with a single capture/compare register. A control word sets the counter running and chooses the job of the register. In compare mode the register holds a value that the counter is checked against. A match raises the interrupt. If clear-on-match is selected, the match also folds the count back to zero. In capture mode the register takes a copy of the running count when a chosen edge appears on one of two asynchronous input pins. The two pins are the primary pin and the secondary pin.

The two pins do not use their edge setting in the same way. The secondary pin captures on exactly the edge its field names. The primary pin captures on the edge opposite to the one its field names. If the primary field is set to both edges, that pin never captures. A one-cycle interrupt pulse is produced by a compare match, by a secondary-pin capture, or by a one-shot trigger. The one-shot trigger is a bus write that restarts the count. Software reaches the block through a small synchronous read/write port with four word addresses.

The core is a two-state machine. ST_STOPPED holds the count frozen and accepts writes to the register. ST_COUNTING advances the count and blocks writes to the register. The START transition (ST_STOPPED to ST_COUNTING) is taken on the first clock that sees the run bit set, and it loads the count with zero. The HALT transition (ST_COUNTING to ST_STOPPED) is taken on the first clock that sees the run bit cleared.

Top module: `edge_cap_timer`

Bus map:
- Address 0 is the control word.
- Address 1 is the capture/compare register.
- Address 2 is the count, which is read-only.
- Address 3 is the one-shot trigger, which is write-only and reads as zero.

Control word layout:
- Bit 0 is run.
- Bit 1 is clear-on-match.
- Bits 3:2 are the source select. Code 11 selects primary-pin capture, code 01 selects secondary-pin capture, and codes 00 and 10 select compare.
- Bits 5:4 are the primary edge field.
- Bits 7:6 are the secondary edge field.

Edge field codes: 00 means falling, 01 means rising, 11 means both, and 10 means no valid edge.

## Requirements
- R1: After reset the control word, the register, the count and irq are all zero and the timer is stopped.
- R2: A write that sets run puts the count at 0 two clocks after the write edge. The count then rises by one per clock. After run is cleared the count stays constant.
- R3: In free-running mode the count wraps from FFFFh to 0000h and keeps counting.
- R4: In compare mode (source 00 or 10), irq is high for exactly the one clock that follows the clock in which the count equals the register.
- R5: With clear-on-match set, the count becomes 0 on the clock after it equals the register. The count period is therefore the register value plus one.
- R6: In free-running compare mode with the register at 0000h, no match occurs before the first wrap. After the wrap, irq pulses as the count moves from 0000h to 0001h.
- R7: While clear-on-match is set, a write of 0000h to the register is rejected and the old value stays. In free-running mode the same write is accepted.
- R8: Register writes made while the timer is counting are ignored.
- R9: With source 11, the primary pin captures on the edge opposite to its field: field 00 captures on rising, field 01 captures on falling, and field 11 never captures. These captures raise no irq.
- R10: With source 01, the secondary pin captures on the edge its field names (00 falling, 01 rising, 11 both). Each capture raises a one-clock irq pulse.
- R11: The edge code 10 never causes a capture on either pin.
- R12: Pins pass through a two-flop synchronizer. The stored value is the count as it stood just before the third clock edge after the pin change.
- R13: A write to address 3 while counting zeroes the count on that edge and pulses irq on the next cycle.
- R14: When a bus read of the register falls in the cycle that ends with a capture edge, the stored value is still the new count. The read data for that cycle is either the old value or the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 2 | Bus word address |
| wdata | input | 16 | Bus write data |
| rdata | output | 16 | Bus read data (combinational from addr) |
| pin_a | input | 1 | Primary capture pin, asynchronous |
| pin_b | input | 1 | Secondary capture pin, asynchronous |
| irq | output | 1 | One-clock interrupt pulse |

## Verification
A capture and a bus read of the same register can land in the same cycle. The bench provokes this by raising the secondary pin and then reading the register in the cycle whose closing edge performs the capture. It works out that cycle from the two synchronizer stages and the edge register. The read data for that cycle passes if it equals either the old value or the arithmetically expected new count. The next read must return the new count exactly.

// File: rtl/cct_pkg.sv
package cct_pkg;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_NONE = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        SRC_CMP_A = 2'b00,
        SRC_SEC   = 2'b01,
        SRC_CMP_B = 2'b10,
        SRC_PRI   = 2'b11
    } src_sel_e;

    typedef enum logic {
        ST_STOPPED  = 1'b0,
        ST_COUNTING = 1'b1
    } run_state_e;

    typedef struct packed {
        edge_sel_e edge_b;
        edge_sel_e edge_a;
        src_sel_e  src;
        logic      clr_mode;
        logic      run;
    } ctrl_t;

    localparam int CTRL_BITS = $bits(ctrl_t);

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CCR  = 2'd1;
    localparam logic [1:0] ADDR_CNT  = 2'd2;
    localparam logic [1:0] ADDR_TRIG = 2'd3;

    function automatic logic is_compare(input src_sel_e s);
        return (s == SRC_CMP_A) || (s == SRC_CMP_B);
    endfunction

    // Primary pin: capture edge is the inverse of its field; both -> none.
    // Secondary pin: capture edge equals its field.
    function automatic logic cap_hit(input ctrl_t c, input logic ra, input logic fa,
                                     input logic rb, input logic fb);
        logic hit;
        hit = 1'b0;
        case (c.src)
            SRC_PRI: begin
                case (c.edge_a)
                    EDGE_FALL: hit = ra;
                    EDGE_RISE: hit = fa;
                    default:   hit = 1'b0;
                endcase
            end
            SRC_SEC: begin
                case (c.edge_b)
                    EDGE_FALL: hit = fb;
                    EDGE_RISE: hit = rb;
                    EDGE_BOTH: hit = rb | fb;
                    default:   hit = 1'b0;
                endcase
            end
            default: hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/cct_edge_sync.sv
module cct_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int LAST = STAGES;

    // stages 0..STAGES-1 synchronize, stage STAGES holds the previous sample
    logic [LAST:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[LAST-1:0], pin};
        end
    end

    assign rise =  shreg[LAST-1] & ~shreg[LAST];
    assign fall = ~shreg[LAST-1] &  shreg[LAST];

    a_r12_edge_from_history: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> ($past(shreg[LAST-2]) && !shreg[LAST]));

endmodule

// File: rtl/cct_regs.sv
module cct_regs
    import cct_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    input  logic         counting,
    input  logic         cap_now,
    input  logic [W-1:0] cnt,
    output ctrl_t        ctrl,
    output logic [W-1:0] ccr,
    output logic         oneshot,
    output logic [W-1:0] rdata
);
    localparam int PAD = W - CTRL_BITS;

    logic wr_ctrl, wr_ccr, ccr_accept;

    assign wr_ctrl    = wr_en && (addr == ADDR_CTRL);
    assign wr_ccr     = wr_en && (addr == ADDR_CCR);
    assign ccr_accept = wr_ccr && !counting && !(ctrl.clr_mode && (wdata == '0));
    assign oneshot    = wr_en && (addr == ADDR_TRIG) && counting;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl <= ctrl_t'(wdata[CTRL_BITS-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ccr <= '0;
        end else if (cap_now) begin
            ccr <= cnt;
        end else if (ccr_accept) begin
            ccr <= wdata;
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_CTRL: rdata = {{PAD{1'b0}}, ctrl};
            ADDR_CCR:  rdata = ccr;
            ADDR_CNT:  rdata = cnt;
            ADDR_TRIG: rdata = '0;
        endcase
    end

    a_r8_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && wr_ccr && !cap_now) |=> $stable(ccr));

    a_r7_zero_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (!counting && wr_ccr && ctrl.clr_mode && wdata == '0) |=> $stable(ccr));

    a_r14_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
        cap_now |=> (ccr == $past(cnt)));

endmodule

// File: rtl/cct_core.sv
module cct_core
    import cct_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ctrl_t        ctrl,
    input  logic [W-1:0] ccr,
    input  logic         oneshot,
    input  logic         cap_irq,
    output logic [W-1:0] cnt,
    output logic         counting,
    output logic         live,
    output logic         irq
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    run_state_e state, state_nxt;
    logic       wrapped;
    logic       match;
    logic       reload;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_STOPPED;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_STOPPED:  if (ctrl.run)  state_nxt = ST_COUNTING;  // START
            ST_COUNTING: if (!ctrl.run) state_nxt = ST_STOPPED;   // HALT
        endcase
    end

    assign counting = (state == ST_COUNTING);
    assign live     = counting && ctrl.run;

    // A zero compare value only matches once the count has wrapped.
    assign match  = live && is_compare(ctrl.src) && (cnt == ccr) &&
                    ((ccr != '0) || wrapped);
    assign reload = oneshot || (match && ctrl.clr_mode);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            wrapped <= 1'b0;
        end else if (state == ST_STOPPED && ctrl.run) begin
            cnt     <= '0;
            wrapped <= 1'b0;
        end else if (live) begin
            if (reload) begin
                cnt <= '0;
                if (oneshot) wrapped <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
                if (cnt == CNT_MAX) wrapped <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= live && (match || cap_irq || oneshot);
        end
    end

    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !reload) |=> (cnt == $past(cnt) + 1'b1));

    a_r2_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!counting && !ctrl.run) |=> $stable(cnt));

    a_r5_clear_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (match && ctrl.clr_mode) |=> (cnt == '0));

    a_r4_match_irq: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> irq);

    a_r13_trigger_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (live && oneshot) |=> (irq && cnt == '0));

    a_r1_stopped_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!counting) |=> !irq);

endmodule

// File: rtl/edge_cap_timer.sv
module edge_cap_timer
    import cct_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic         pin_a,
    input  logic         pin_b,
    output logic         irq
);
    localparam int NPINS = 2;

    logic [NPINS-1:0] pins, rise, fall;
    ctrl_t            ctrl;
    logic [W-1:0]     ccr, cnt;
    logic             counting, live, oneshot, cap_now, cap_irq;

    assign pins = {pin_b, pin_a};

    generate
        for (genvar g = 0; g < NPINS; g++) begin : g_pin
            cct_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .pin  (pins[g]),
                .rise (rise[g]),
                .fall (fall[g])
            );
        end
    endgenerate

    assign cap_now = live && cap_hit(ctrl, rise[0], fall[0], rise[1], fall[1]);
    assign cap_irq = cap_now && (ctrl.src == SRC_SEC);

    cct_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .counting(counting),
        .cap_now (cap_now),
        .cnt     (cnt),
        .ctrl    (ctrl),
        .ccr     (ccr),
        .oneshot (oneshot),
        .rdata   (rdata)
    );

    cct_core #(.W(W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl    (ctrl),
        .ccr     (ccr),
        .oneshot (oneshot),
        .cap_irq (cap_irq),
        .cnt     (cnt),
        .counting(counting),
        .live    (live),
        .irq     (irq)
    );

    a_r9_primary_dead_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (live && ctrl.src == SRC_PRI && (ctrl.edge_a == EDGE_BOTH || ctrl.edge_a == EDGE_NONE))
        |=> $stable(ccr));

    a_r11_secondary_dead_code: assert property (@(posedge clk) disable iff (!rst_n)
        (live && ctrl.src == SRC_SEC && ctrl.edge_b == EDGE_NONE) |=> $stable(ccr));

    a_r10_secondary_irq: assert property (@(posedge clk) disable iff (!rst_n)
        cap_irq |=> irq);

endmodule

// File: tb/test_edge_cap_timer.sv
`timescale 1ns/100ps
module test_edge_cap_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        pin_a = 1'b0;
    logic        pin_b = 1'b0;
    logic        irq;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int start_cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    edge_cap_timer i_edge_cap_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_a(pin_a), .pin_b(pin_b), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d, output int wc);
        @(negedge clk);
        wc = cyc;
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    task automatic start(input logic [7:0] cb);
        int wc;
        wr(2'd0, {8'h00, cb}, wc);
        start_cyc = wc + 2;
    endtask

    task automatic stop_then_load(input logic [15:0] val);
        int wc;
        wr(2'd0, 16'h0000, wc);
        wr(2'd1, val, wc);
    endtask

    task automatic idle_cnt(input int n, inout int pulses);
        repeat (n) begin
            @(negedge clk);
            if (irq) pulses++;
        end
    endtask

    task automatic set_pin(input bit on_b, input logic lvl);
        if (on_b) pin_b = lvl; else pin_a = lvl;
    endtask

    // One capture scenario: rising pulse then falling edge on the chosen pin.
    task automatic cap_case(input logic [7:0] cb, input bit on_b, input bit exp_r,
                            input bit exp_f, input bit exp_irq, input string tag);
        int m, v, exp_v, pulses;
        stop_then_load(16'hABCD);
        start(cb);
        pulses = 0;
        exp_v = 16'hABCD;
        idle_cnt(10, pulses);
        @(negedge clk); m = cyc; set_pin(on_b, 1'b1);
        idle_cnt(5, pulses);
        rd(2'd1, v);
        if (exp_r) exp_v = m + 2 - start_cyc;
        chk({tag, " rising"}, v, exp_v);
        @(negedge clk); m = cyc; set_pin(on_b, 1'b0);
        idle_cnt(5, pulses);
        rd(2'd1, v);
        if (exp_f) exp_v = m + 2 - start_cyc;
        chk({tag, " falling"}, v, exp_v);
        chk({tag, " irq pulses"}, pulses, exp_irq ? (int'(exp_r) + int'(exp_f)) : 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int v, a, b, wc, mism, m, pulses, pulse_at;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 0);
        rd(2'd1, v); chk("R1 ccr", v, 0);
        rd(2'd2, v); chk("R1 count", v, 0);
        chk("R1 irq", int'(irq), 0);

        // R2 counting from start, then hold after stop
        wr(2'd1, 16'd1000, wc);
        start(8'h01);
        repeat (7) @(negedge clk);
        rd(2'd2, v); chk("R2 count", v, cyc - start_cyc);
        wr(2'd0, 16'h0000, wc);
        repeat (2) @(negedge clk);
        rd(2'd2, a);
        repeat (5) @(negedge clk);
        rd(2'd2, b); chk("R2 hold", b, a);

        // R4 compare sweep, free-running
        foreach (cmp_vals[i]) begin
            stop_then_load(cmp_vals[i][15:0]);
            start(8'h01);
            mism = 0;
            for (int k = 0; k < cmp_vals[i] + 8; k++) begin
                @(negedge clk);
                if (int'(irq) != int'(cyc == start_cyc + cmp_vals[i] + 1)) mism++;
            end
            chk("R4 irq timing", mism, 0);
        end

        // R5 clear-on-match with value 5
        stop_then_load(16'd5);
        start(8'h03);
        mism = 0;
        pulses = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            rd(2'd2, v);
            if (v != (cyc - start_cyc) % 6) mism++;
            if (int'(irq) != int'((cyc - start_cyc) % 6 == 0 && cyc > start_cyc)) pulses++;
        end
        chk("R5 count period", mism, 0);
        chk("R4 irq in clear mode", pulses, 0);

        // R7 zero write rejected in clear mode, accepted in free mode
        wr(2'd0, 16'h0002, wc);
        repeat (2) @(negedge clk);
        wr(2'd1, 16'h0000, wc);
        rd(2'd1, v); chk("R7 zero rejected", v, 5);
        wr(2'd0, 16'h0000, wc);
        wr(2'd1, 16'h0000, wc);
        rd(2'd1, v); chk("R7 zero accepted free", v, 0);
        wr(2'd1, 16'd300, wc);

        // R8 write while counting ignored
        start(8'h01);
        repeat (3) @(negedge clk);
        wr(2'd1, 16'd77, wc);
        rd(2'd1, v); chk("R8 write ignored", v, 300);

        // R3 / R6 wrap with zero compare value
        stop_then_load(16'h0000);
        start(8'h01);
        pulses = 0;
        pulse_at = -1;
        for (int k = 0; k < 65545; k++) begin
            @(negedge clk);
            if (irq) begin pulses++; pulse_at = cyc; end
            if (cyc == start_cyc + 65535) begin rd(2'd2, v); chk("R3 top", v, 65535); end
            if (cyc == start_cyc + 65536) begin rd(2'd2, v); chk("R3 wrap", v, 0); end
            if (cyc == start_cyc + 65537) begin rd(2'd2, v); chk("R6 count at irq", v, 1); end
        end
        chk("R6 pulse count", pulses, 1);
        chk("R6 pulse cycle", pulse_at, start_cyc + 65537);

        // R9 primary pin: opposite edge, both/none never capture, no irq
        cap_case(8'h0D, 1'b0, 1'b1, 1'b0, 1'b0, "R9 field00");
        cap_case(8'h1D, 1'b0, 1'b0, 1'b1, 1'b0, "R9 field01");
        cap_case(8'h3D, 1'b0, 1'b0, 1'b0, 1'b0, "R9 field11");
        cap_case(8'h2D, 1'b0, 1'b0, 1'b0, 1'b0, "R11 primary field10");

        // R10 secondary pin: same edge, with irq; R12 latency in the values
        cap_case(8'h05, 1'b1, 1'b0, 1'b1, 1'b1, "R10 field00");
        cap_case(8'h45, 1'b1, 1'b1, 1'b0, 1'b1, "R10 field01 R12");
        cap_case(8'hC5, 1'b1, 1'b1, 1'b1, 1'b1, "R10 field11");
        cap_case(8'h85, 1'b1, 1'b0, 1'b0, 1'b1, "R11 secondary field10");

        // R14 read in the cycle that ends with the capture edge
        stop_then_load(16'hABCD);
        start(8'h45);
        repeat (4) @(negedge clk);
        @(negedge clk); m = cyc; pin_b = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd(2'd1, v);
        chk("R14 read old or new", int'(v == 16'hABCD || v == m + 2 - start_cyc), 1);
        @(negedge clk);
        rd(2'd1, v); chk("R14 stored value", v, m + 2 - start_cyc);
        pin_b = 1'b0;
        repeat (5) @(negedge clk);

        // R13 one-shot trigger
        stop_then_load(16'd50000);
        start(8'h01);
        repeat (30) @(negedge clk);
        wr(2'd3, 16'h0000, wc);
        chk("R13 irq", int'(irq), 1);
        rd(2'd2, v); chk("R13 count cleared", v, 0);
        @(negedge clk);
        rd(2'd2, v); chk("R13 count resumes", v, 1);
        chk("R13 irq single", int'(irq), 0);

        finish_run();
    end

    int cmp_vals[4] = '{1, 2, 7, 40};

endmodule